// File: doc/BRIEF.md
# Prioritized Interrupt State Vector Register

This block sits inside a serial data-link controller and gathers eight interrupt conditions raised by the link layer. Each condition is latched as a sticky flag. The highest-priority pending flag is encoded as a level from 1 to 8, and level 0 means that nothing is pending. The level is presented on the CPU register bus already multiplied by four, so software can add the byte read from the vector register straight to the base of a jump table of four-byte entries.

Clearing a flag follows the kind of source. For ordinary status sources, the vector read that reports a source also retires it. Data-related sources stay pending until the vector read is followed by the matching data-register access. The transmit-empty source can also be retired by a one-shot end-of-data control bit. After an invalid-symbol flag is retired, receive and transmit stay disabled until an end-of-frame event arrives. Setting either loopback bit cuts the node off from the bus, and bus-side events are then dropped.

Top module: `isv_top`

## Requirements
- R1: The reported level is the highest set flag, with `ev_src` bit i raising level i+1. The levels are: 1 end-of-frame, 2 in-frame-response byte, 3 receive full, 4 transmit empty, 5 arbitration lost, 6 CRC error, 7 invalid symbol, 8 wakeup (highest).
- R2: Reading address 0 returns the level in bits 5..2, with every other bit zero. The possible values are 0x00 and 0x04 up to 0x20.
- R3: A vector read that reports level 1, 5, 6, 7 or 8 clears that flag at the next clock edge.
- R4: A vector read that reports level 2 or 3 leaves the flag set. The flag clears only when a data-register read (address 2, which returns `rx_data`) follows that vector read.
- R5: The transmit-empty flag clears on a data-register write that follows a vector read reporting level 4. It also clears on any control write (address 1) with bit 2 set.
- R6: The pending vector-then-data sequence is dropped by any vector read of another level and by any data access. A data access that is not armed clears nothing.
- R7: If a flag's event pulse and its clear fall in the same cycle, the flag stays set.
- R8: A vector read that reports level 7 drives `link_en` low from the next cycle. While `link_en` is low, level 2 and 3 events are ignored. An end-of-frame event raises `link_en` again.
- R9: Control bits 0 and 1 are the two loopback controls. While either is set, `link_isolated` is high and every event except transmit empty is ignored.
- R10: `irq` is high exactly when the level is non-zero.
- R11: After reset all flags and the pending sequence are clear, the vector reads 0x00, the control register reads 0x00 and `link_en` is high.
- R12: Reading the control register returns the two loopback bits in bits 1..0. Bit 2 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 vector, 1 control, 2 data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| rx_data | input | 8 | Received byte shown at the data address |
| ev_src | input | 8 | One-cycle event pulses, bit i for level i+1 |
| irq | output | 1 | Interrupt request |
| link_en | output | 1 | Receive and transmit allowed |
| link_isolated | output | 1 | Node disconnected from the bus by loopback |

## Verification
A wrong flag or a wrong pending-sequence state shows up at the very next vector read. Either a stale level is still reported or a lower level appears one read too early, so each scenario reads the vector after every single access. A lost block or a lost isolation state makes a later dropped event appear as a non-zero vector, and this is observed on the first read after the pulse. `irq` and `link_en` are sampled one cycle after each causing access, because both follow registered state with a single register of delay.

// File: rtl/isv_pkg.sv
package isv_pkg;
    localparam int LVL_W = 4;
    localparam int NSRC  = 8;
    localparam int CTL_W = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LV_NONE = 4'd0;
    localparam lvl_t LV_EOF  = 4'd1;
    localparam lvl_t LV_IFR  = 4'd2;
    localparam lvl_t LV_RXF  = 4'd3;
    localparam lvl_t LV_TXE  = 4'd4;
    localparam lvl_t LV_SYM  = 4'd7;

    // bit i of a source vector belongs to level i+1
    localparam logic [NSRC-1:0] BUS_SRC_MASK = 8'b1111_0111;
    localparam logic [NSRC-1:0] BLK_SRC_MASK = 8'b0000_0110;

    localparam int C_LOOP_A = 0;
    localparam int C_LOOP_D = 1;
    localparam int C_ENDTX  = 2;

    typedef enum logic [1:0] {
        RA_VEC  = 2'd0,
        RA_CTL  = 2'd1,
        RA_DAT  = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/isv_flag_bank.sv
module isv_flag_bank
    import isv_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] drop,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag_q
);
    typedef struct packed {
        logic [N-1:0] flag;
    } fb_state_t;

    fb_state_t s_d, s_q;
    logic [N-1:0] set_ok;

    for (genvar g = 0; g < N; g++) begin : g_src
        assign set_ok[g] = ev[g] & ~drop[g];
    end

    always_comb begin
        s_d = s_q;
        // a set in the same cycle overrides any clear
        s_d.flag = (s_q.flag & ~clr) | set_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag_q = s_q.flag;
endmodule

// File: rtl/isv_prio_enc.sv
module isv_prio_enc
    import isv_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] flags,
    output lvl_t         level
);
    logic [N:0] above;
    lvl_t       lvl_of [N];

    // above[i] is high when some flag at index >= i is set
    assign above[N] = 1'b0;
    for (genvar g = N - 1; g >= 0; g--) begin : g_chain
        assign above[g]  = above[g+1] | flags[g];
        assign lvl_of[g] = (flags[g] & ~above[g+1]) ? lvl_t'(g + 1) : LV_NONE;
    end

    always_comb begin
        level = LV_NONE;
        for (int i = 0; i < N; i++) begin
            level = level | lvl_of[i];
        end
    end
endmodule

// File: rtl/isv_seq.sv
module isv_seq
    import isv_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vec_rd,
    input  logic             dat_rd,
    input  logic             dat_wr,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  lvl_t             level,
    input  logic             eof_ok,
    output logic [N-1:0]     clr,
    output logic [1:0]       loop_q,
    output logic             block_q
);
    typedef struct packed {
        logic       armed;
        lvl_t       arm_lvl;
        logic [1:0] loop;
        logic       block;
    } seq_state_t;

    seq_state_t s_d, s_q;

    function automatic logic [N-1:0] lvl_onehot(input lvl_t l);
        logic [N-1:0] m;
        m = '0;
        for (int i = 0; i < N; i++) begin
            if (l == lvl_t'(i + 1)) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic is_data_src(input lvl_t l);
        return (l == LV_IFR) || (l == LV_RXF) || (l == LV_TXE);
    endfunction

    always_comb begin
        s_d = s_q;
        clr = '0;

        if (s_q.block && eof_ok) s_d.block = 1'b0;

        if (vec_rd) begin
            if (is_data_src(level)) begin
                s_d.armed   = 1'b1;
                s_d.arm_lvl = level;
            end else begin
                s_d.armed   = 1'b0;
                s_d.arm_lvl = LV_NONE;
                clr         = lvl_onehot(level);
                if (level == LV_SYM) s_d.block = 1'b1;
            end
        end

        if (dat_rd || dat_wr) begin
            if (s_q.armed) begin
                if (dat_rd && (s_q.arm_lvl == LV_IFR || s_q.arm_lvl == LV_RXF))
                    clr = clr | lvl_onehot(s_q.arm_lvl);
                if (dat_wr && s_q.arm_lvl == LV_TXE)
                    clr = clr | lvl_onehot(LV_TXE);
            end
            s_d.armed   = 1'b0;
            s_d.arm_lvl = LV_NONE;
        end

        if (ctl_wr) begin
            s_d.loop = {ctl_wdata[C_LOOP_D], ctl_wdata[C_LOOP_A]};
            if (ctl_wdata[C_ENDTX]) clr = clr | lvl_onehot(LV_TXE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign loop_q  = s_q.loop;
    assign block_q = s_q.block;
endmodule

// File: rtl/isv_top.sv
module isv_top
    import isv_pkg::*;
#(
    parameter int DW        = 8,
    parameter int VEC_SHIFT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      bus_addr,
    input  logic            bus_rd,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [DW-1:0]   rx_data,
    input  logic [NSRC-1:0] ev_src,
    output logic            irq,
    output logic            link_en,
    output logic            link_isolated
);
    logic            vec_rd, dat_rd, dat_wr, ctl_wr;
    logic [NSRC-1:0] flags, clr_vec, drop;
    logic [1:0]      loop;
    logic            blocked, isolated, eof_ok;
    lvl_t            level;
    logic [DW-1:0]   vec_byte, ctl_byte;
    logic            wdata_unused;

    assign vec_rd = bus_rd && (bus_addr == RA_VEC);
    assign dat_rd = bus_rd && (bus_addr == RA_DAT);
    assign dat_wr = bus_wr && (bus_addr == RA_DAT);
    assign ctl_wr = bus_wr && (bus_addr == RA_CTL);
    assign wdata_unused = ^bus_wdata[DW-1:CTL_W];

    assign isolated = |loop;
    assign drop     = (isolated ? BUS_SRC_MASK : '0) | (blocked ? BLK_SRC_MASK : '0);
    assign eof_ok   = ev_src[0] & ~isolated;

    isv_flag_bank #(.N(NSRC)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev_src),
        .drop   (drop),
        .clr    (clr_vec),
        .flag_q (flags)
    );

    isv_prio_enc #(.N(NSRC)) u_enc (
        .flags (flags),
        .level (level)
    );

    isv_seq #(.N(NSRC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .vec_rd    (vec_rd),
        .dat_rd    (dat_rd),
        .dat_wr    (dat_wr),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (bus_wdata[CTL_W-1:0]),
        .level     (level),
        .eof_ok    (eof_ok),
        .clr       (clr_vec),
        .loop_q    (loop),
        .block_q   (blocked)
    );

    always_comb begin
        vec_byte = '0;
        vec_byte[VEC_SHIFT +: LVL_W] = level;
        ctl_byte = '0;
        ctl_byte[1:0] = loop;
        case (bus_addr)
            RA_VEC:  bus_rdata = vec_byte;
            RA_CTL:  bus_rdata = ctl_byte;
            RA_DAT:  bus_rdata = rx_data;
            default: bus_rdata = '0;
        endcase
    end

    assign irq           = (level != LV_NONE);
    assign link_en       = ~blocked;
    assign link_isolated = isolated;
endmodule

// File: rtl/isv_checker.sv
module isv_checker #(
    parameter int DW = 8,
    parameter int N  = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    bus_addr,
    input logic          bus_rd,
    input logic [DW-1:0] bus_rdata,
    input logic          irq,
    input logic          link_en,
    input logic          link_isolated,
    input logic [N-1:0]  flag_q,
    input logic [N-1:0]  clr
);
    p_vec_format_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd0) |->
        (bus_rdata[1:0] == 2'b00 && bus_rdata[DW-1:6] == '0 && bus_rdata[5:2] <= 4'd8));

    p_idle_vector_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd0 && !irq) |-> (bus_rdata == '0));

    p_sticky_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flag_q) & ~$past(clr)) & ~flag_q) == '0);

    p_data_src_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd0 && bus_rdata == 8'h0C) |=> irq);

    p_block_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_en) |-> $past(bus_rd && bus_addr == 2'd0 && bus_rdata == 8'h1C));

    p_isolated_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (link_isolated && !flag_q[N-1]) |=> !flag_q[N-1]);
endmodule

bind isv_top isv_checker #(.DW(DW), .N(isv_pkg::NSRC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_rd        (bus_rd),
    .bus_rdata     (bus_rdata),
    .irq           (irq),
    .link_en       (link_en),
    .link_isolated (link_isolated),
    .flag_q        (flags),
    .clr           (clr_vec)
);

// File: tb/sim_isv_top.sv
module sim_isv_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd3;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] rx_data = 8'hA5;
    logic [7:0] ev_src = 8'h00;
    logic       irq, link_en, link_isolated;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    isv_top u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_rd        (bus_rd),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .rx_data       (rx_data),
        .ev_src        (ev_src),
        .irq           (irq),
        .link_en       (link_en),
        .link_isolated (link_isolated)
    );

    // driver: one bus cycle per call, expected read data goes to the scoreboard
    task automatic cyc(input logic [1:0] a, input logic rd, input logic wr,
                       input logic [7:0] wd, input logic [7:0] ev,
                       input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd; ev_src = ev;
        if (rd) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
    endtask

    task automatic rd_vec(input logic [7:0] e, input string t); cyc(2'd0, 1'b1, 1'b0, 8'h00, 8'h00, e, t); endtask
    task automatic rd_ctl(input logic [7:0] e, input string t); cyc(2'd1, 1'b1, 1'b0, 8'h00, 8'h00, e, t); endtask
    task automatic rd_dat(input string t);                      cyc(2'd2, 1'b1, 1'b0, 8'h00, 8'h00, 8'hA5, t); endtask
    task automatic wr_dat();                                    cyc(2'd2, 1'b0, 1'b1, 8'h3C, 8'h00, 8'h00, ""); endtask
    task automatic wr_ctl(input logic [7:0] v);                 cyc(2'd1, 1'b0, 1'b1, v, 8'h00, 8'h00, ""); endtask
    task automatic pulse(input logic [7:0] m);                  cyc(2'd3, 1'b0, 1'b0, 8'h00, m, 8'h00, ""); endtask

    // idle cycle, then compare the sideband outputs directly
    task automatic look(input string t, input logic e_irq, input logic e_len, input logic e_iso);
        cyc(2'd3, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, "");
        #1;
        n_cmp++;
        if ({irq, link_en, link_isolated} !== {e_irq, e_len, e_iso}) begin
            n_bad++;
            $display("FAIL %s irq/link_en/isolated act=%b%b%b exp=%b%b%b",
                     t, irq, link_en, link_isolated, e_irq, e_len, e_iso);
        end
    endtask

    // monitor: pops one expected item per read strobe
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (bus_rd) begin
                n_cmp++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL scoreboard empty act=%h exp=none", bus_rdata);
                end else begin
                    logic [7:0] e;
                    string      t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (bus_rdata !== e) begin
                        n_bad++;
                        $display("FAIL %s rdata act=%h exp=%h", t, bus_rdata, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state, R12 control readback
        look("R11", 1'b0, 1'b1, 1'b0);
        rd_vec(8'h00, "R11");
        rd_ctl(8'h00, "R11_R12");

        // R1 R2 R3 R10: single source and ordinary clear
        pulse(8'h01);
        look("R10", 1'b1, 1'b1, 1'b0);
        rd_vec(8'h04, "R1");
        rd_vec(8'h00, "R3");
        pulse(8'h21);
        rd_vec(8'h18, "R1");
        rd_vec(8'h04, "R3");
        rd_vec(8'h00, "R3");

        // R4: receive full needs vector read then data read
        pulse(8'h04);
        rd_vec(8'h0C, "R4");
        rd_vec(8'h0C, "R4");
        rd_dat("R4");
        rd_vec(8'h00, "R4");
        look("R10", 1'b0, 1'b1, 1'b0);
        pulse(8'h02);
        rd_vec(8'h08, "R4");
        rd_dat("R4");
        rd_vec(8'h00, "R4");

        // R6: data write disarms, unarmed data read clears nothing
        pulse(8'h04);
        rd_vec(8'h0C, "R6");
        wr_dat();
        rd_dat("R6");
        rd_vec(8'h0C, "R6");
        rd_dat("R6");
        rd_vec(8'h00, "R6");

        // R5: transmit empty by data write, then by end-of-data bit
        pulse(8'h08);
        rd_vec(8'h10, "R5");
        wr_dat();
        rd_vec(8'h00, "R5");
        pulse(8'h08);
        wr_ctl(8'h04);
        rd_vec(8'h00, "R5");
        rd_ctl(8'h00, "R12");

        // R6: a vector read of another level disarms
        pulse(8'h08);
        rd_vec(8'h10, "R6");
        pulse(8'h10);
        rd_vec(8'h14, "R6");
        wr_dat();
        rd_vec(8'h10, "R6");
        wr_dat();
        rd_vec(8'h00, "R6");

        // R7: set and clear in one cycle
        pulse(8'h80);
        cyc(2'd0, 1'b1, 1'b0, 8'h00, 8'h80, 8'h20, "R7");
        rd_vec(8'h20, "R7");
        rd_vec(8'h00, "R7");

        // R8: invalid symbol blocks until end of frame
        pulse(8'h40);
        rd_vec(8'h1C, "R8");
        look("R8", 1'b0, 1'b0, 1'b0);
        pulse(8'h06);
        rd_vec(8'h00, "R8");
        pulse(8'h01);
        look("R8", 1'b1, 1'b1, 1'b0);
        rd_vec(8'h04, "R8");
        pulse(8'h04);
        rd_vec(8'h0C, "R8");
        rd_dat("R8");
        rd_vec(8'h00, "R8");

        // R9: loopback isolation
        wr_ctl(8'h01);
        rd_ctl(8'h01, "R12");
        look("R9", 1'b0, 1'b1, 1'b1);
        pulse(8'hF7);
        rd_vec(8'h00, "R9");
        pulse(8'h08);
        rd_vec(8'h10, "R9");
        wr_ctl(8'h02);
        rd_ctl(8'h02, "R12");
        pulse(8'h20);
        rd_vec(8'h10, "R9");
        wr_ctl(8'h04);
        rd_ctl(8'h00, "R12");
        look("R9", 1'b0, 1'b1, 1'b0);
        rd_vec(8'h00, "R9");

        // R1 R2: full priority walk
        pulse(8'hBF);
        rd_vec(8'h20, "R2");
        rd_vec(8'h18, "R2");
        rd_vec(8'h14, "R2");
        rd_vec(8'h10, "R1");
        wr_dat();
        rd_vec(8'h0C, "R1");
        rd_dat("R1");
        rd_vec(8'h08, "R1");
        rd_dat("R1");
        rd_vec(8'h04, "R1");
        rd_vec(8'h00, "R1");
        look("R10", 1'b0, 1'b1, 1'b0);

        repeat (3) cyc(2'd3, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, "");
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard left act=%0d exp=0", exp_q.size());
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule